// File: doc/BRIEF.md
# Interleaved DDR IQ Sample Port

This block sits on the baseband side of a two-channel radio link. Twelve-bit in-phase and quadrature samples for two MIMO channels (A and B) travel over one shared parallel word bus. A side flag line travels with the bus. The transmit half takes four parallel sample inputs and places them on its bus as a repeating frame of words. In double-data-rate operation one word goes out in the high phase of the port clock and one in the low phase. In single-data-rate operation one word goes out per clock period.

The receive half captures its bus on the rising edge and on the falling edge of the port clock. It rebuilds the same frames and presents the four samples in parallel, all updated at once, with a one-period valid strobe. In the default multiplexed mode the flag tells I words from Q words, and the receiver uses it to recover frame alignment. In the alternative mode the flag only qualifies which bus words carry data. A single-channel setting shortens the frame to one I/Q pair.

Top module: `iq_ddr_port`

## Requirements
- R1: While rst_n is low and at the first clock edge after it, rx_valid is 0, every receive sample output is 0, rx_resync_cnt is 0 and the transmit bus and flag are 0.
- R2: With cfg_ddr=1 and cfg_mimo=1, the receiver takes the words of a frame in the order A-I, A-Q, B-I, B-Q. The first word is captured on a rising edge, the next on the following falling edge, and so on. I words carry flag 1 and Q words flag 0. All four outputs change together and rx_valid is 1 for exactly one period. That period begins at the rising edge one clock period after the rising edge that opened the period in which the last word was carried.
- R3: With cfg_ddr=0 the receiver takes one word per rising edge, with the same order and latency as R2. Bus and flag values present at falling edges are ignored.
- R4: With cfg_mimo=0 a frame is two words, I then Q, and it updates only rx_ai and rx_aq. rx_bi and rx_bq keep the values of the last two-channel frame.
- R5: In multiplexed mode the transmitter repeats the frame A-I, A-Q, B-I, B-Q, or only A-I, A-Q when cfg_mimo=0. tx_flag is 1 on I words and 0 on Q words. With cfg_ddr=1 it drives one word while clk is high and the next while clk is low. With cfg_ddr=0 it drives one word for each full period, and the word changes at the rising edge.
- R6: The transmitter samples all four tx inputs together at the rising edge that emits a frame's first word. Input changes after that edge do not appear on the bus until the next frame.
- R7: In multiplexed mode, a flag-1 word arriving where a Q word is expected is taken as the A-I word of a new frame. The partial frame is discarded and rx_resync_cnt increases by one for each such word. A frame may complete in the same clock period as a resync.
- R8: In multiplexed mode, a flag-0 word arriving where an I word is expected is dropped. The frame restarts at A-I and the resync count does not change.
- R9: With cfg_flag_en=1 the flag acts as a word enable. The receiver fills frame slots in order from flag-1 words only, ignores flag-0 words and never changes rx_resync_cnt. The transmitter drives tx_flag=1 on every word.
- R10: A frame cut short after reset never raises rx_valid, and the receive outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; both bus edges are referenced to it |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ddr | input | 1 | 1: two words per period, 0: one word per period |
| cfg_mimo | input | 1 | 1: two-channel four-word frame, 0: single-channel pair |
| cfg_flag_en | input | 1 | 1: flag is a word enable, 0: flag marks I words |
| tx_ai | input | 12 | Channel A in-phase sample to send |
| tx_aq | input | 12 | Channel A quadrature sample to send |
| tx_bi | input | 12 | Channel B in-phase sample to send |
| tx_bq | input | 12 | Channel B quadrature sample to send |
| tx_bus | output | 12 | Transmit word bus |
| tx_flag | output | 1 | Transmit word flag |
| rx_bus | input | 12 | Receive word bus |
| rx_flag | input | 1 | Receive word flag |
| rx_ai | output | 12 | Received channel A in-phase sample |
| rx_aq | output | 12 | Received channel A quadrature sample |
| rx_bi | output | 12 | Received channel B in-phase sample |
| rx_bq | output | 12 | Received channel B quadrature sample |
| rx_valid | output | 1 | One-period strobe for a complete frame |
| rx_resync_cnt | output | 8 | Saturating count of realignment events |

## Verification
Realignment and frame completion can fall in the same clock period, because each period takes two words in double-data-rate mode. In single-channel mode, a flag-1 word on the rising edge at the Q slot forces a resync. The flag-0 word on the following falling edge then completes the new frame at once. The bench judges this case by the output pair, by exactly one extra valid pulse and by a count that rises by one. It also drives a flag-1 word at the last slot of a two-channel frame and checks that the rebuilt frame starts from that word.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
    // Frame slots in transfer order: 0 A-I, 1 A-Q, 2 B-I, 3 B-Q
    localparam int SLOTS = 4;
    localparam int LANES = 2;
    localparam int PW    = $clog2(SLOTS);

    function automatic logic [PW-1:0] last_slot(input logic two_ch);
        return two_ch ? PW'(SLOTS - 1) : PW'(1);
    endfunction
endpackage

// File: rtl/iq_tx_framer.sv
module iq_tx_framer
    import iq_port_pkg::*;
#(
    parameter int WW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ddr,
    input  logic          cfg_mimo,
    input  logic          cfg_flag_en,
    input  logic [WW-1:0] in_ai,
    input  logic [WW-1:0] in_aq,
    input  logic [WW-1:0] in_bi,
    input  logic [WW-1:0] in_bq,
    output logic [WW-1:0] bus_out,
    output logic          flag_out
);
    typedef struct packed {
        logic [SLOTS-1:0][WW-1:0] hold;
        logic [PW-1:0]            pos;
        logic [WW-1:0]            rise_w;
        logic                     rise_f;
        logic [WW-1:0]            pend_w;
        logic                     pend_f;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic [WW-1:0] fall_w_q;
    logic          fall_f_q;

    always_comb begin
        logic [SLOTS-1:0][WW-1:0] src;
        logic [WW-1:0]            w;
        logic                     f;
        logic [PW-1:0]            last;
        st_d = st_q;
        src  = st_q.hold;
        last = last_slot(cfg_mimo);
        w    = '0;
        f    = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (k == 0 || cfg_ddr) begin
                if (st_d.pos == '0) begin
                    src[0] = in_ai;
                    src[1] = in_aq;
                    src[2] = in_bi;
                    src[3] = in_bq;
                    st_d.hold = src;
                end
                w = src[st_d.pos];
                f = cfg_flag_en ? 1'b1 : ~st_d.pos[0];
                if (k == 0) begin
                    st_d.rise_w = w;
                    st_d.rise_f = f;
                end else begin
                    st_d.pend_w = w;
                    st_d.pend_f = f;
                end
                st_d.pos = (st_d.pos == last) ? '0 : st_d.pos + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_w_q <= '0;
            fall_f_q <= 1'b0;
        end else begin
            fall_w_q <= st_q.pend_w;
            fall_f_q <= st_q.pend_f;
        end
    end

    assign bus_out  = (cfg_ddr && !clk) ? fall_w_q : st_q.rise_w;
    assign flag_out = (cfg_ddr && !clk) ? fall_f_q : st_q.rise_f;

    // R6: the sample set only reloads when a lane reaches slot 0
    a_r6_no_tear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pos != '0) && (!cfg_ddr || st_q.pos != last_slot(cfg_mimo)) |=> $stable(st_q.hold));

    // R5: single-channel single-rate flag alternates I/Q every period
    a_r5_flag_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_flag_en && !cfg_ddr && !cfg_mimo |=> st_q.rise_f != $past(st_q.rise_f));
endmodule

// File: rtl/iq_rx_deframer.sv
module iq_rx_deframer
    import iq_port_pkg::*;
#(
    parameter int WW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ddr,
    input  logic          cfg_mimo,
    input  logic          cfg_flag_en,
    input  logic [WW-1:0] bus_in,
    input  logic          flag_in,
    output logic [WW-1:0] out_ai,
    output logic [WW-1:0] out_aq,
    output logic [WW-1:0] out_bi,
    output logic [WW-1:0] out_bq,
    output logic          out_valid,
    output logic [CW-1:0] resync_cnt
);
    typedef struct packed {
        logic [WW-1:0]            rise_w;
        logic                     rise_f;
        logic [PW-1:0]            pos;
        logic [SLOTS-1:0][WW-1:0] stage;
        logic [SLOTS-1:0][WW-1:0] outv;
        logic                     valid;
        logic [CW-1:0]            cnt;
    } rx_st_t;

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    rx_st_t st_d, st_q;
    logic [WW-1:0] fall_w_q;
    logic          fall_f_q;

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_w_q <= '0;
            fall_f_q <= 1'b0;
        end else begin
            fall_w_q <= bus_in;
            fall_f_q <= flag_in;
        end
    end

    always_comb begin
        logic [LANES-1:0][WW-1:0] lane_w;
        logic [LANES-1:0]         lane_f;
        logic [LANES-1:0]         lane_on;
        logic                     take;
        logic [PW-1:0]            slot;
        logic [PW-1:0]            last;
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.rise_w = bus_in;
        st_d.rise_f = flag_in;
        lane_w[0]   = st_q.rise_w;
        lane_f[0]   = st_q.rise_f;
        lane_w[1]   = fall_w_q;
        lane_f[1]   = fall_f_q;
        lane_on[0]  = 1'b1;
        lane_on[1]  = cfg_ddr;
        last        = last_slot(cfg_mimo);
        take        = 1'b0;
        slot        = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_on[k]) begin
                take = 1'b0;
                slot = st_d.pos;
                if (cfg_flag_en) begin
                    take = lane_f[k];
                end else if (lane_f[k] && st_d.pos[0]) begin
                    take = 1'b1;
                    slot = '0;
                    if (st_d.cnt != CNT_MAX) st_d.cnt = st_d.cnt + CW'(1);
                end else if (!lane_f[k] && !st_d.pos[0]) begin
                    st_d.pos = '0;
                end else begin
                    take = 1'b1;
                end
                if (take) begin
                    st_d.stage[slot] = lane_w[k];
                    if (slot == last) begin
                        st_d.outv[0] = st_d.stage[0];
                        st_d.outv[1] = st_d.stage[1];
                        if (cfg_mimo) begin
                            st_d.outv[2] = st_d.stage[2];
                            st_d.outv[3] = st_d.stage[3];
                        end
                        st_d.valid = 1'b1;
                        st_d.pos   = '0;
                    end else begin
                        st_d.pos = slot + PW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_ai     = st_q.outv[0];
    assign out_aq     = st_q.outv[1];
    assign out_bi     = st_q.outv[2];
    assign out_bq     = st_q.outv[3];
    assign out_valid  = st_q.valid;
    assign resync_cnt = st_q.cnt;

    // R2: parallel outputs move only together with the valid strobe
    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.outv));

    // R4: single-channel frames leave channel B untouched
    a_r4_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mimo |=> $stable(st_q.outv[2]) && $stable(st_q.outv[3]));

    // R9: in enable mode nothing is counted as a realignment
    a_r9_no_resync_count: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flag_en |=> $stable(st_q.cnt));
endmodule

// File: rtl/iq_ddr_port.sv
module iq_ddr_port #(
    parameter int WW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ddr,
    input  logic          cfg_mimo,
    input  logic          cfg_flag_en,
    input  logic [WW-1:0] tx_ai,
    input  logic [WW-1:0] tx_aq,
    input  logic [WW-1:0] tx_bi,
    input  logic [WW-1:0] tx_bq,
    output logic [WW-1:0] tx_bus,
    output logic          tx_flag,
    input  logic [WW-1:0] rx_bus,
    input  logic          rx_flag,
    output logic [WW-1:0] rx_ai,
    output logic [WW-1:0] rx_aq,
    output logic [WW-1:0] rx_bi,
    output logic [WW-1:0] rx_bq,
    output logic          rx_valid,
    output logic [CW-1:0] rx_resync_cnt
);
    iq_tx_framer #(.WW(WW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ddr    (cfg_ddr),
        .cfg_mimo   (cfg_mimo),
        .cfg_flag_en(cfg_flag_en),
        .in_ai      (tx_ai),
        .in_aq      (tx_aq),
        .in_bi      (tx_bi),
        .in_bq      (tx_bq),
        .bus_out    (tx_bus),
        .flag_out   (tx_flag)
    );

    iq_rx_deframer #(.WW(WW), .CW(CW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ddr    (cfg_ddr),
        .cfg_mimo   (cfg_mimo),
        .cfg_flag_en(cfg_flag_en),
        .bus_in     (rx_bus),
        .flag_in    (rx_flag),
        .out_ai     (rx_ai),
        .out_aq     (rx_aq),
        .out_bi     (rx_bi),
        .out_bq     (rx_bq),
        .out_valid  (rx_valid),
        .resync_cnt (rx_resync_cnt)
    );
endmodule

// File: tb/iq_ddr_port_test.sv
module iq_ddr_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ddr = 1'b1, cfg_mimo = 1'b1, cfg_flag_en = 1'b0;
    logic [11:0] tx_ai = '0, tx_aq = '0, tx_bi = '0, tx_bq = '0;
    logic [11:0] tx_bus;
    logic        tx_flag;
    logic [11:0] rx_bus = '0;
    logic        rx_flag = 1'b0;
    logic [11:0] rx_ai, rx_aq, rx_bi, rx_bq;
    logic        rx_valid;
    logic [7:0]  rx_resync_cnt;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    bit done = 0;

    always #2 clk = ~clk;

    iq_ddr_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_ddr(cfg_ddr), .cfg_mimo(cfg_mimo),
        .cfg_flag_en(cfg_flag_en), .tx_ai(tx_ai), .tx_aq(tx_aq), .tx_bi(tx_bi),
        .tx_bq(tx_bq), .tx_bus(tx_bus), .tx_flag(tx_flag), .rx_bus(rx_bus),
        .rx_flag(rx_flag), .rx_ai(rx_ai), .rx_aq(rx_aq), .rx_bi(rx_bi),
        .rx_bq(rx_bq), .rx_valid(rx_valid), .rx_resync_cnt(rx_resync_cnt)
    );

    always @(negedge clk) if (rst_n && rx_valid) vcount++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_bus = '0;
        rx_flag = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    // one clock period: rise word before the rising edge, fall word after it
    task automatic cyc(input logic [11:0] rw, input logic rf, input logic [11:0] fw, input logic ff);
        @(negedge clk);
        #1 rx_bus = rw; rx_flag = rf;
        @(posedge clk);
        #1 rx_bus = fw; rx_flag = ff;
    endtask

    task automatic idle();
        cyc(12'h000, 1'b0, 12'h000, 1'b0);
    endtask

    task automatic rx_frame(input string tag, input logic [11:0] base, input logic m,
                            input logic [11:0] eb0, input logic [11:0] eb1);
        logic [11:0] w[4];
        int flen;
        int v0;
        flen = m ? 4 : 2;
        for (int s = 0; s < 4; s++) w[s] = base + 12'(s * 17);
        v0 = vcount;
        if (cfg_ddr) begin
            for (int p = 0; p < flen / 2; p++) cyc(w[2*p], 1'b1, w[2*p+1], 1'b0);
        end else begin
            for (int s = 0; s < flen; s++) cyc(w[s], (s % 2) == 0, 12'hFFF ^ 12'(s), 1'b1);
        end
        check({tag, " valid not early"}, rx_valid, 0);
        idle();
        check({tag, " valid"}, rx_valid, 1);
        check({tag, " ai"}, rx_ai, w[0]);
        check({tag, " aq"}, rx_aq, w[1]);
        check({tag, " bi"}, rx_bi, m ? w[2] : eb0);
        check({tag, " bq"}, rx_bq, m ? w[3] : eb1);
        idle();
        check({tag, " valid one period"}, rx_valid, 0);
        check({tag, " one pulse"}, vcount - v0, 1);
    endtask

    task automatic tx_sweep(input logic d, input logic m, input logic e);
        logic [11:0] v[4];
        int flen;
        int s;
        for (int k = 0; k < 4; k++) v[k] = 12'(k * 101 + int'({d, m, e}) * 37 + 5);
        cfg_ddr = d; cfg_mimo = m; cfg_flag_en = e;
        tx_ai = v[0]; tx_aq = v[1]; tx_bi = v[2]; tx_bq = v[3];
        do_reset();
        flen = m ? 4 : 2;
        for (int n = 0; n < 8; n++) begin
            if (d && (n % 2 == 1)) @(negedge clk);
            else                   @(posedge clk);
            #1;
            s = n % flen;
            check("R5 tx word order", tx_bus, v[s]);
            if (e) check("R9 tx flag enable", tx_flag, 1);
            else   check("R5 tx flag marks I", tx_flag, (s % 2) == 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        int v0;
        // R1 reset state
        repeat (2) @(negedge clk);
        #1;
        check("R1 rx_valid", rx_valid, 0);
        check("R1 rx_ai", rx_ai, 0);
        check("R1 rx_bq", rx_bq, 0);
        check("R1 resync", rx_resync_cnt, 0);
        check("R1 tx_bus", tx_bus, 0);
        check("R1 tx_flag", tx_flag, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 rx_valid after release", rx_valid, 0);

        // R5, R9 transmit sweep over every mode combination
        for (int c = 0; c < 8; c++) tx_sweep(c[2], c[1], c[0]);

        // R6 mid-frame input change does not tear the frame
        cfg_ddr = 1; cfg_mimo = 1; cfg_flag_en = 0;
        tx_ai = 12'h111; tx_aq = 12'h222; tx_bi = 12'h333; tx_bq = 12'h444;
        do_reset();
        @(posedge clk); #1;
        check("R6 first A-I", tx_bus, 12'h111);
        tx_ai = 12'hA11; tx_aq = 12'hA22; tx_bi = 12'hA33; tx_bq = 12'hA44;
        @(negedge clk); #1; check("R6 A-Q old", tx_bus, 12'h222);
        @(posedge clk); #1; check("R6 B-I old", tx_bus, 12'h333);
        @(negedge clk); #1; check("R6 B-Q old", tx_bus, 12'h444);
        @(posedge clk); #1; check("R6 next A-I new", tx_bus, 12'hA11);
        @(negedge clk); #1; check("R6 next A-Q new", tx_bus, 12'hA22);

        // R2, R3, R4 receive sweep in both data rates
        for (int d = 0; d < 2; d++) begin
            cfg_ddr = d[0]; cfg_mimo = 1; cfg_flag_en = 0;
            do_reset();
            rx_frame(d ? "R2 ddr mimo" : "R3 sdr mimo", 12'h100 + 12'(d * 8), 1'b1, 0, 0);
            rx_frame(d ? "R2 ddr mimo" : "R3 sdr mimo", 12'h500 + 12'(d * 8), 1'b1, 0, 0);
            cfg_mimo = 0;
            rx_frame(d ? "R4 ddr single" : "R4 sdr single", 12'h900 + 12'(d * 8), 1'b0,
                     12'h500 + 12'(d * 8) + 12'd34, 12'h500 + 12'(d * 8) + 12'd51);
            rx_frame(d ? "R4 ddr single" : "R4 sdr single", 12'hC00 + 12'(d * 8), 1'b0,
                     12'h500 + 12'(d * 8) + 12'd34, 12'h500 + 12'(d * 8) + 12'd51);
            check("R7 no resync in clean stream", rx_resync_cnt, 0);
        end

        // R7 flag-1 word in Q slot restarts the frame
        cfg_ddr = 1; cfg_mimo = 1; cfg_flag_en = 0;
        do_reset();
        v0 = vcount;
        cyc(12'h010, 1, 12'h011, 0);
        cyc(12'h012, 1, 12'h7A0, 1);
        cyc(12'h7A1, 0, 12'h7A2, 1);
        cyc(12'h7A3, 0, 12'h000, 0);
        idle();
        check("R7 valid", rx_valid, 1);
        check("R7 ai", rx_ai, 12'h7A0);
        check("R7 aq", rx_aq, 12'h7A1);
        check("R7 bi", rx_bi, 12'h7A2);
        check("R7 bq", rx_bq, 12'h7A3);
        check("R7 count", rx_resync_cnt, 1);
        idle();
        check("R7 one pulse", vcount - v0, 1);

        // R7 resync and completion in the same period (single channel, DDR)
        cfg_mimo = 0;
        do_reset();
        v0 = vcount;
        cyc(12'h0A0, 1, 12'h0A1, 0);
        cyc(12'h0B0, 1, 12'h0B1, 1);
        cyc(12'h0C0, 1, 12'h0C1, 0);
        idle();
        check("R7 same-period valid", rx_valid, 1);
        check("R7 same-period ai", rx_ai, 12'h0C0);
        check("R7 same-period aq", rx_aq, 12'h0C1);
        check("R7 same-period count", rx_resync_cnt, 2);
        idle();
        check("R7 same-period pulses", vcount - v0, 2);

        // R8 flag-0 word in I slot is dropped without counting
        cfg_mimo = 1;
        do_reset();
        v0 = vcount;
        cyc(12'h201, 1, 12'h202, 0);
        cyc(12'h2EE, 0, 12'h2EF, 0);
        cyc(12'h301, 1, 12'h302, 0);
        cyc(12'h303, 1, 12'h304, 0);
        idle();
        check("R8 valid", rx_valid, 1);
        check("R8 ai", rx_ai, 12'h301);
        check("R8 aq", rx_aq, 12'h302);
        check("R8 bi", rx_bi, 12'h303);
        check("R8 bq", rx_bq, 12'h304);
        check("R8 count unchanged", rx_resync_cnt, 0);
        idle();
        check("R8 one pulse", vcount - v0, 1);

        // R10 partial frame after reset produces nothing
        do_reset();
        v0 = vcount;
        cyc(12'h401, 1, 12'h402, 0);
        repeat (4) idle();
        check("R10 no pulse", vcount - v0, 0);
        check("R10 ai stays zero", rx_ai, 0);
        check("R10 aq stays zero", rx_aq, 0);

        // R9 flag as word enable on receive
        cfg_flag_en = 1;
        do_reset();
        v0 = vcount;
        cyc(12'h601, 1, 12'h6FF, 0);
        cyc(12'h602, 1, 12'h603, 1);
        cyc(12'h6FE, 0, 12'h604, 1);
        idle();
        check("R9 valid", rx_valid, 1);
        check("R9 ai", rx_ai, 12'h601);
        check("R9 aq", rx_aq, 12'h602);
        check("R9 bi", rx_bi, 12'h603);
        check("R9 bq", rx_bq, 12'h604);
        check("R9 count", rx_resync_cnt, 0);
        idle();
        check("R9 one pulse", vcount - v0, 1);

        report();
    end
endmodule